// File: doc/BRIEF.md
# Timer Interrupt Flag Register

This block holds the pending-interrupt flags of four timer/counters in two byte-wide registers. The primary register holds flags for timers 0, 1 and 2. The extended register holds the flags of timer 3 and the third compare channel of timer 1. The timer counters live outside the block. They report capture edges, counter-at-TOP, overflow and compare-equal conditions as inputs, and every one of these is qualified by a shared timer-tick enable.

Software reads either register over a small register bus and clears flags by writing ones. The interrupt controller clears a flag by pulsing that flag's acknowledge line when the vector runs. Each flag drives an interrupt request through its own enable bit.

Compare flags are deliberately one tick late. A forced-compare strobe is never allowed to raise a flag. The capture flag can take its set condition from the counter reaching TOP instead of from the capture pin.

Top module: `timer_irq_flags`

## Requirements
- R1: After reset every flag, every interrupt request and the read data are zero.
- R2: With `addr`=0 the read data shows the primary flags at these positions: bit 7 timer 2 compare, bit 6 timer 2 overflow, bit 5 timer 1 capture, bit 4 timer 1 compare A, bit 3 timer 1 compare B, bit 2 timer 1 overflow, bit 1 timer 0 compare, bit 0 timer 0 overflow.
- R3: With `addr`=1 the read data shows the extended flags at these positions: bit 5 timer 3 capture, bit 4 timer 3 compare A, bit 3 timer 3 compare B, bit 2 timer 3 overflow, bit 1 timer 3 compare C, bit 0 timer 1 compare C. Bits 7:6 always read zero, and writing ones to them changes nothing.
- R4: A register write clears each flag of the addressed register whose `wdata` bit is one. Flags whose bit is zero are left unchanged.
- R5: A pulse on a flag's acknowledge line (`ack_main`/`ack_ext`, same bit positions as the registers) clears that flag.
- R6: A compare flag sets on the tick after the tick at which its `cmp_eq` bit was high. `cmp_eq`/`force_cmp` indices are: 0 timer 0, 1 timer 2, 2 timer 1 A, 3 timer 1 B, 4 timer 1 C, 5 timer 3 A, 6 timer 3 B, 7 timer 3 C.
- R7: A compare-equal accompanied by the matching `force_cmp` bit never sets the flag.
- R8: When `cap_top[i]` is 0, capture flag i (index 0 timer 1, 1 timer 3) sets on `cap_edge[i]` and ignores `at_top[i]`. When `cap_top[i]` is 1, it sets on `at_top[i]` and ignores `cap_edge[i]`.
- R9: When `ovf_sel[i]` is 0, overflow flag i (index = timer number) sets on `ovf_wrap[i]`. When it is 1, the flag sets on `ovf_modal[i]` instead.
- R10: When a set event coincides with a write-one or an acknowledge on the same flag, the flag ends set.
- R11: Timer events presented while `tick` is low have no effect.
- R12: Each interrupt request is high exactly while its flag and its enable are both high, including in the same cycle the enable rises over an already set flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer clock enable, qualifies all timer events |
| cmp_eq | input | 8 | Counter-equals-compare indications |
| force_cmp | input | 8 | Forced-compare strobes |
| ovf_wrap | input | 4 | Counter overflow events, timers 0..3 |
| ovf_modal | input | 4 | Mode-dependent overflow events, timers 0..3 |
| ovf_sel | input | 4 | Selects the mode-dependent overflow source |
| cap_edge | input | 2 | Capture pin events, timers 1 and 3 |
| at_top | input | 2 | Counter reached TOP, timers 1 and 3 |
| cap_top | input | 2 | Capture register acts as TOP |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read enable |
| addr | input | 1 | 0 primary, 1 extended register |
| wdata | input | 8 | Write data, ones clear flags |
| rdata | output | 8 | Read data, zero when rd_en is low |
| ack_main | input | 8 | Vector acknowledge, primary flags |
| ack_ext | input | 6 | Vector acknowledge, extended flags |
| en_main | input | 8 | Interrupt enables, primary flags |
| en_ext | input | 6 | Interrupt enables, extended flags |
| flags_main | output | 8 | Primary flag register |
| flags_ext | output | 6 | Extended flag register |
| irq_main | output | 8 | Interrupt requests, primary flags |
| irq_ext | output | 6 | Interrupt requests, extended flags |

## Verification
The hardest case to reach from the ports is the hidden pending stage of a compare flag. A match is seen on one tick but must not show until the next tick, and untick'd cycles in between must neither lose nor advance it. The stimulus therefore places a match on a tick, follows it with a cycle where the tick is low, and only then gives a bare tick. It also presents a match while the tick is low and then a bare tick, to show that no pending state was formed. The forced-compare case is driven the same way, with the strobe on the match tick and the flag observed after the following tick.

// File: rtl/timer_irq_flags.sv
module timer_irq_flags #(
  parameter int NCMP = 8,
  parameter int NTMR = 4,
  parameter int NCAP = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [NCMP-1:0] cmp_eq,
  input  logic [NCMP-1:0] force_cmp,
  input  logic [NTMR-1:0] ovf_wrap,
  input  logic [NTMR-1:0] ovf_modal,
  input  logic [NTMR-1:0] ovf_sel,
  input  logic [NCAP-1:0] cap_edge,
  input  logic [NCAP-1:0] at_top,
  input  logic [NCAP-1:0] cap_top,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic            addr,
  input  logic [7:0]      wdata,
  output logic [7:0]      rdata,
  input  logic [7:0]      ack_main,
  input  logic [5:0]      ack_ext,
  input  logic [7:0]      en_main,
  input  logic [5:0]      en_ext,
  output logic [7:0]      flags_main,
  output logic [5:0]      flags_ext,
  output logic [7:0]      irq_main,
  output logic [5:0]      irq_ext
);

  logic [NCMP-1:0] cmp_pend;
  logic [NCAP-1:0] cap_src;
  logic [NTMR-1:0] ovf_src;
  logic [7:0]      set_main, clr_main;
  logic [5:0]      set_ext, clr_ext;

  assign cap_src = (cap_top & at_top) | (~cap_top & cap_edge);
  assign ovf_src = (ovf_sel & ovf_modal) | (~ovf_sel & ovf_wrap);

  assign set_main = {8{tick}} & {cmp_pend[1], ovf_src[2], cap_src[0], cmp_pend[2],
                                 cmp_pend[3], ovf_src[1], cmp_pend[0], ovf_src[0]};
  assign set_ext  = {6{tick}} & {cap_src[1], cmp_pend[5], cmp_pend[6],
                                 ovf_src[3], cmp_pend[7], cmp_pend[4]};

  assign clr_main = ack_main | ((wr_en && !addr) ? wdata : 8'h00);
  assign clr_ext  = ack_ext  | ((wr_en &&  addr) ? wdata[5:0] : 6'h00);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_pend   <= '0;
      flags_main <= '0;
      flags_ext  <= '0;
    end else begin
      if (tick) cmp_pend <= cmp_eq & ~force_cmp;
      flags_main <= (flags_main & ~clr_main) | set_main;
      flags_ext  <= (flags_ext  & ~clr_ext)  | set_ext;
    end
  end

  assign irq_main = flags_main & en_main;
  assign irq_ext  = flags_ext  & en_ext;
  assign rdata    = !rd_en ? 8'h00 : (addr ? {2'b00, flags_ext} : flags_main);

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|{set_ext, set_main}) |=>
      (({flags_ext, flags_main} & $past({set_ext, set_main})) == $past({set_ext, set_main})));

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|({clr_ext, clr_main} & ~{set_ext, set_main})) |=>
      (({flags_ext, flags_main} & $past({clr_ext, clr_main} & ~{set_ext, set_main})) == 14'h0));

  assert_no_tick_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> (({flags_ext, flags_main} & ~$past({flags_ext, flags_main})) == 14'h0));

  assert_force_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (|force_cmp)) |=> ((cmp_pend & $past(force_cmp)) == '0));

  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    addr |-> (rdata[7:6] == 2'b00));

  assert_cmp_late_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_main[4]) |-> ($past(tick) && $past(cmp_pend[2] || (flags_main[4] && !clr_main[4]))));

endmodule

// File: tb/timer_irq_flags_test.sv
`timescale 1ns/1ps
module timer_irq_flags_test;

  typedef struct {
    string      req;
    logic [7:0] m;
    logic [5:0] e;
    logic [7:0] im;
    logic [5:0] ie;
    logic [7:0] rd;
  } item_t;

  logic clk = 0, rst_n = 0, tick = 0;
  logic [7:0] cmp_eq = 0, force_cmp = 0;
  logic [3:0] ovf_wrap = 0, ovf_modal = 0, ovf_sel = 0;
  logic [1:0] cap_edge = 0, at_top = 0, cap_top = 0;
  logic wr_en = 0, rd_en = 1, addr = 0;
  logic [7:0] wdata = 0, rdata, ack_main = 0, en_main = 0, flags_main, irq_main;
  logic [5:0] ack_ext = 0, en_ext = 0, flags_ext, irq_ext;

  item_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  timer_irq_flags uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmp_eq(cmp_eq), .force_cmp(force_cmp),
    .ovf_wrap(ovf_wrap), .ovf_modal(ovf_modal), .ovf_sel(ovf_sel),
    .cap_edge(cap_edge), .at_top(at_top), .cap_top(cap_top),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .ack_main(ack_main), .ack_ext(ack_ext), .en_main(en_main), .en_ext(en_ext),
    .flags_main(flags_main), .flags_ext(flags_ext), .irq_main(irq_main), .irq_ext(irq_ext));

  task automatic step(string req, logic [7:0] m, logic [5:0] e,
                      logic [7:0] im, logic [5:0] ie, logic [7:0] rd);
    item_t it;
    @(posedge clk);
    it.req = req; it.m = m; it.e = e; it.im = im; it.ie = ie; it.rd = rd;
    q.push_back(it);
    @(negedge clk);
    #1;
    tick = 0; cmp_eq = 0; force_cmp = 0; ovf_wrap = 0; ovf_modal = 0;
    cap_edge = 0; at_top = 0; wr_en = 0; wdata = 0; ack_main = 0; ack_ext = 0;
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (flags_main !== it.m || flags_ext !== it.e || irq_main !== it.im ||
          irq_ext !== it.ie || rdata !== it.rd) begin
        errors++;
        $display("FAIL %s: main=%h ext=%h irqm=%h irqe=%h rd=%h expected main=%h ext=%h irqm=%h irqe=%h rd=%h",
                 it.req, flags_main, flags_ext, irq_main, irq_ext, rdata,
                 it.m, it.e, it.im, it.ie, it.rd);
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1; rst_n = 1;
    step("R1 reset state", 8'h00, 6'h00, 8'h00, 6'h00, 8'h00);
    tick = 1; ovf_wrap[0] = 1;
    step("R2 timer0 overflow bit0", 8'h01, 6'h00, 8'h00, 6'h00, 8'h01);
    ovf_wrap[2] = 1; cap_edge[0] = 1; cmp_eq[1] = 1;
    step("R11 events without tick", 8'h01, 6'h00, 8'h00, 6'h00, 8'h01);
    tick = 1;
    step("R11 no pending from untick'd match", 8'h01, 6'h00, 8'h00, 6'h00, 8'h01);
    wr_en = 1; wdata = 8'h00;
    step("R4 write zero keeps", 8'h01, 6'h00, 8'h00, 6'h00, 8'h01);
    wr_en = 1; wdata = 8'h01;
    step("R4 write one clears", 8'h00, 6'h00, 8'h00, 6'h00, 8'h00);
    tick = 1; cmp_eq[2] = 1;
    step("R6 match tick no flag yet", 8'h00, 6'h00, 8'h00, 6'h00, 8'h00);
    step("R6 idle cycle keeps pending hidden", 8'h00, 6'h00, 8'h00, 6'h00, 8'h00);
    tick = 1;
    step("R6 next tick sets compare A", 8'h10, 6'h00, 8'h00, 6'h00, 8'h10);
    tick = 1; cmp_eq[3] = 1; force_cmp[3] = 1;
    step("R7 forced match tick", 8'h10, 6'h00, 8'h00, 6'h00, 8'h10);
    tick = 1;
    step("R7 forced match never sets", 8'h10, 6'h00, 8'h00, 6'h00, 8'h10);
    ack_main[4] = 1;
    step("R5 acknowledge clears", 8'h00, 6'h00, 8'h00, 6'h00, 8'h00);
    tick = 1; at_top[0] = 1;
    step("R8 top ignored in pin mode", 8'h00, 6'h00, 8'h00, 6'h00, 8'h00);
    tick = 1; cap_edge[0] = 1;
    step("R8 capture edge sets", 8'h20, 6'h00, 8'h00, 6'h00, 8'h20);
    wr_en = 1; wdata = 8'h20;
    step("R4 clear capture", 8'h00, 6'h00, 8'h00, 6'h00, 8'h00);
    cap_top[0] = 1; tick = 1; cap_edge[0] = 1;
    step("R8 edge ignored in top mode", 8'h00, 6'h00, 8'h00, 6'h00, 8'h00);
    tick = 1; at_top[0] = 1;
    step("R8 top sets in top mode", 8'h20, 6'h00, 8'h00, 6'h00, 8'h20);
    tick = 1; ovf_modal[1] = 1;
    step("R9 modal ignored in normal mode", 8'h20, 6'h00, 8'h00, 6'h00, 8'h20);
    tick = 1; ovf_wrap[1] = 1;
    step("R9 wrap sets overflow", 8'h24, 6'h00, 8'h00, 6'h00, 8'h24);
    ack_main[2] = 1;
    step("R5 acknowledge overflow", 8'h20, 6'h00, 8'h00, 6'h00, 8'h20);
    ovf_sel[1] = 1; tick = 1; ovf_wrap[1] = 1;
    step("R9 wrap ignored in modal mode", 8'h20, 6'h00, 8'h00, 6'h00, 8'h20);
    tick = 1; ovf_modal[1] = 1;
    step("R9 modal sets overflow", 8'h24, 6'h00, 8'h00, 6'h00, 8'h24);
    addr = 1; tick = 1; cap_edge[1] = 1;
    step("R3 timer3 capture bit5", 8'h24, 6'h20, 8'h00, 6'h00, 8'h20);
    addr = 1; wr_en = 1; wdata = 8'hC0;
    step("R3 reserved writes ignored", 8'h24, 6'h20, 8'h00, 6'h00, 8'h20);
    tick = 1; cmp_eq[4] = 1;
    step("R3 timer1 C match tick", 8'h24, 6'h20, 8'h00, 6'h00, 8'h20);
    tick = 1;
    step("R3 timer1 C bit0", 8'h24, 6'h21, 8'h00, 6'h00, 8'h21);
    tick = 1; ovf_wrap[3] = 1;
    step("R3 timer3 overflow bit2", 8'h24, 6'h25, 8'h00, 6'h00, 8'h25);
    tick = 1; cmp_eq[7] = 1;
    step("R3 timer3 C match tick", 8'h24, 6'h25, 8'h00, 6'h00, 8'h25);
    tick = 1;
    step("R3 timer3 C bit1", 8'h24, 6'h27, 8'h00, 6'h00, 8'h27);
    tick = 1; cmp_eq[5] = 1; cmp_eq[6] = 1;
    step("R3 timer3 A B match tick", 8'h24, 6'h27, 8'h00, 6'h00, 8'h27);
    tick = 1;
    step("R3 timer3 A B bits 4 3", 8'h24, 6'h3F, 8'h00, 6'h00, 8'h3F);
    ack_ext[1] = 1;
    step("R5 extended acknowledge", 8'h24, 6'h3D, 8'h00, 6'h00, 8'h3D);
    wr_en = 1; wdata = 8'hFF;
    step("R4 extended write clears only extended", 8'h24, 6'h00, 8'h00, 6'h00, 8'h00);
    addr = 0;
    step("R2 primary readback", 8'h24, 6'h00, 8'h00, 6'h00, 8'h24);
    tick = 1; ovf_wrap[0] = 1; wr_en = 1; wdata = 8'h01; ack_main[0] = 1;
    step("R10 set wins over clear", 8'h25, 6'h00, 8'h00, 6'h00, 8'h25);
    en_main = 8'h01;
    step("R12 enable over set flag", 8'h25, 6'h00, 8'h01, 6'h00, 8'h25);
    en_main = 8'h02; en_ext = 6'h3F;
    step("R12 enable over clear flag", 8'h25, 6'h00, 8'h00, 6'h00, 8'h25);
    tick = 1; cap_edge[1] = 1;
    step("R12 extended request follows flag", 8'h25, 6'h20, 8'h00, 6'h20, 8'h25);
    tick = 1; cmp_eq[0] = 1; cmp_eq[1] = 1;
    step("R6 timer0 timer2 match tick", 8'h25, 6'h20, 8'h00, 6'h20, 8'h25);
    tick = 1; ovf_wrap[2] = 1;
    step("R2 timer2 and timer0 positions", 8'hE7, 6'h20, 8'h02, 6'h20, 8'hE7);
    rd_en = 0;
    step("R1 read disabled gives zero", 8'hE7, 6'h20, 8'h02, 6'h20, 8'h00);
    repeat (2) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule